// File: doc/BRIEF.md
# Complementary FIR Audio Crossover

This block divides a mono stream of signed audio samples into a low band and a high band for a two-way active loudspeaker. A symmetric FIR filter produces the low band. One multiplier serves it: mirrored history samples are added first, so the two taps that share a coefficient cost one cycle. The high band is not filtered. It is the input, delayed to the filter's centre tap, minus the low band. Adding the two bands therefore always gives back the delayed input exactly.

Samples enter on a valid/ready handshake. A sample offered while `in_ready` is low is dropped. It does not enter the history, and the source is expected to wait for `in_ready`. The output side is a plain one-cycle strobe with no back-pressure. The words hold their value until the next update. The results for a sample are presented when the next sample is accepted, so the output lags by exactly one sample period. Two coefficient sets, one for each supported sample rate, are computed into an on-chip ROM at elaboration. A mute condition, raised by a lost link or a rate that is too high, forces both outputs to zero.

Top module: `xover_crossover`

## Requirements
- R1: Each input word of IN_W bits is reduced to its most significant 16 bits, read as a signed sample, before any other use.
- R2: With history x[0] (newest) to x[TAPS-1], and with x taken as zero before the first accepted sample, the low band is floor((sum of c[k]*x[k]) / 2^COEF_SHIFT), saturated to the range -32768..32767. The coefficients are symmetric: c[k] = c[TAPS-1-k].
- R3: With C = (TAPS-1)/2 and m = min(k, TAPS-1-k), rate_sel = 0 gives c[k] = (m+1)*ceil(2^COEF_SHIFT/(C+1)^2). rate_sel = 1 gives c[k] = ceil(2^COEF_SHIFT/TAPS) for all k. The set is the one selected at the edge where the sample is accepted. Each coefficient is stored as an upper and a lower 16-bit half.
- R4: The high band is x[C] - lowband, computed in 32-bit signed arithmetic with no wrap. For example, -32766 - 9 gives -32775.
- R5: lp_word is the 16-bit low band in bits 31:16, with bits 15:0 zero. hp_word is the high band shifted left by 15, with bits 14:0 zero.
- R6: When sample n+1 is accepted, out_valid is high for exactly one cycle after that edge. The words then carry the results for sample n, or zero before the first sample. The words do not change at any other time, except through R8.
- R7: After an accepted sample, in_ready is low for C+3 cycles. A sample offered while in_ready is low changes neither the outputs nor the history.
- R8: At any clock edge where link_ok is low or rate_fast is high, both words become zero after that edge. This includes update edges, where out_valid still pulses.
- R9: After reset, in_ready is 1, out_valid is 0, both words are zero and the history is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block can accept a sample |
| in_word | input | IN_W | Incoming sample word, upper 16 bits used |
| rate_sel | input | 1 | Coefficient set: 0 = lower rate, 1 = higher rate |
| link_ok | input | 1 | Input stream present |
| rate_fast | input | 1 | Detected rate is above the supported ones |
| out_valid | output | 1 | One-cycle strobe for new output words |
| lp_word | output | 32 | Low-band DAC word |
| hp_word | output | 32 | High-band DAC word |

## Verification
The bench builds the block with TAPS = 9, COEF_SHIFT = 12 and IN_W = 24. Under these values the centre delay is only four samples, a whole sample computation takes seven cycles, and the ceiling-rounded coefficients sum to slightly more than unity. Full-scale runs therefore reach low-band saturation in both coefficient sets. A mirrored full-scale pattern drives the high band beyond 16 bits, and an impulse exposes each coefficient in turn. With these short runs, a few hundred random samples with random rate and mute reach all of these cases within a short run time.

// File: rtl/xover_pkg.sv
package xover_pkg;

  localparam int SMP_W = 16;
  localparam int DAC_W = 32;
  localparam int ACC_W = 64;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_FINISH = 2'd3
  } xover_state_t;

  function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [ACC_W-1:0] v);
    if (v > 64'sd32767)       return 16'sh7fff;
    else if (v < -64'sd32768) return 16'sh8000;
    else                      return v[SMP_W-1:0];
  endfunction

endpackage

// File: rtl/xover_history.sv
module xover_history
  import xover_pkg::*;
#(
  parameter int TAPS = 513,
  localparam int CTR   = (TAPS - 1) / 2,
  localparam int NPAIR = CTR + 1,
  localparam int JW    = $clog2(NPAIR + 1),
  localparam int AW    = $clog2(TAPS),
  localparam int IW    = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic signed [SMP_W-1:0] wr_smp,
  input  logic [JW-1:0]           step,
  output logic signed [SMP_W-1:0] near_smp,
  output logic signed [SMP_W-1:0] far_smp
);

  logic signed [SMP_W-1:0] mem [TAPS];
  logic [AW-1:0] wp;
  logic [AW-1:0] newest;
  logic [IW-1:0] idx_near;
  logic [IW-1:0] idx_far;
  logic [IW-1:0] step_x;
  logic [IW-1:0] far_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
      wp     <= '0;
      newest <= '0;
    end else if (wr_en) begin
      mem[wp] <= wr_smp;
      newest  <= wp;
      wp      <= (wp == AW'(TAPS - 1)) ? '0 : wp + 1'b1;
    end
  end

  // near tap = newest - step, far tap = newest - (TAPS-1-step) = newest + 1 + step (mod TAPS)
  always_comb begin
    step_x  = IW'(step);
    if (IW'(newest) >= step_x) idx_near = IW'(newest) - step_x;
    else                       idx_near = IW'(newest) + IW'(TAPS) - step_x;
    far_raw = IW'(newest) + step_x + 1'b1;
    if (far_raw >= IW'(TAPS)) idx_far = far_raw - IW'(TAPS);
    else                      idx_far = far_raw;
  end

  assign near_smp = (idx_near < IW'(TAPS)) ? mem[idx_near[AW-1:0]] : '0;
  assign far_smp  = (idx_far  < IW'(TAPS)) ? mem[idx_far[AW-1:0]]  : '0;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step <= JW'(CTR)) |-> ((idx_near < IW'(TAPS)) && (idx_far < IW'(TAPS)))); // R2

endmodule

// File: rtl/xover_coef_rom.sv
module xover_coef_rom
  import xover_pkg::*;
#(
  parameter int TAPS       = 513,
  parameter int COEF_SHIFT = 38,
  localparam int CTR   = (TAPS - 1) / 2,
  localparam int NPAIR = CTR + 1,
  localparam int JW    = $clog2(NPAIR + 1)
) (
  input  logic               clk,
  input  logic               set_sel,
  input  logic [JW-1:0]      addr,
  output logic signed [31:0] coef
);

  localparam longint unsigned SCALE     = 64'd1 << COEF_SHIFT;
  localparam longint unsigned TRI_DEN   = longint'(NPAIR) * longint'(NPAIR);
  localparam longint unsigned STEP_TRI  = (SCALE + TRI_DEN - 1) / TRI_DEN;
  localparam longint unsigned STEP_FLAT = (SCALE + longint'(TAPS) - 1) / longint'(TAPS);

  logic [15:0] hi_tab [2][NPAIR];
  logic [15:0] lo_tab [2][NPAIR];

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    localparam longint unsigned TRI_V = STEP_TRI * longint'(j + 1);
    assign hi_tab[0][j] = 16'(TRI_V >> 16);
    assign lo_tab[0][j] = 16'(TRI_V);
    assign hi_tab[1][j] = 16'(STEP_FLAT >> 16);
    assign lo_tab[1][j] = 16'(STEP_FLAT);
  end

  always_ff @(posedge clk) begin
    if (addr < JW'(NPAIR)) coef <= $signed({hi_tab[set_sel][addr], lo_tab[set_sel][addr]});
    else                   coef <= '0;
  end

endmodule

// File: rtl/xover_mac.sv
module xover_mac
  import xover_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [SMP_W:0]   pair_sum,
  input  logic signed [31:0]      coef,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [SMP_W+32:0] prod;

  assign prod = pair_sum * coef;

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + ACC_W'(prod);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc[ACC_W-1] == acc[ACC_W-2])); // R2

endmodule

// File: rtl/xover_crossover.sv
module xover_crossover
  import xover_pkg::*;
#(
  parameter int TAPS       = 513,
  parameter int COEF_SHIFT = 38,
  parameter int IN_W       = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_word,
  input  logic            rate_sel,
  input  logic            link_ok,
  input  logic            rate_fast,
  output logic            out_valid,
  output logic [31:0]     lp_word,
  output logic [31:0]     hp_word
);

  localparam int CTR   = (TAPS - 1) / 2;
  localparam int NPAIR = CTR + 1;
  localparam int JW    = $clog2(NPAIR + 1);

  xover_state_t            state;
  logic                    accept;
  logic                    mute;
  logic [JW-1:0]           step;
  logic                    last_step;
  logic                    set_q;
  logic signed [SMP_W:0]   pair_q;
  logic                    pv_q;
  logic signed [SMP_W-1:0] ctr_q;
  logic signed [SMP_W-1:0] smp_in;
  logic signed [SMP_W-1:0] near_smp;
  logic signed [SMP_W-1:0] far_smp;
  logic signed [31:0]      coef;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_sh;
  logic signed [SMP_W-1:0] lp_smp;
  logic signed [31:0]      hp_diff;
  logic [31:0]             pend_lp;
  logic [31:0]             pend_hp;

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign mute      = !link_ok || rate_fast;
  assign smp_in    = in_word[IN_W-1 -: SMP_W];
  assign last_step = (step == JW'(CTR));

  xover_history #(.TAPS(TAPS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_smp   (smp_in),
    .step     (step),
    .near_smp (near_smp),
    .far_smp  (far_smp)
  );

  xover_coef_rom #(.TAPS(TAPS), .COEF_SHIFT(COEF_SHIFT)) u_rom (
    .clk     (clk),
    .set_sel (set_q),
    .addr    (step),
    .coef    (coef)
  );

  xover_mac u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .en       (pv_q),
    .pair_sum (pair_q),
    .coef     (coef),
    .acc      (acc)
  );

  assign acc_sh  = acc >>> COEF_SHIFT;
  assign lp_smp  = sat_smp(acc_sh);
  assign hp_diff = 32'(ctr_q) - 32'(lp_smp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= '0;
      set_q   <= 1'b0;
      pair_q  <= '0;
      pv_q    <= 1'b0;
      ctr_q   <= '0;
      pend_lp <= '0;
      pend_hp <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          pv_q <= 1'b0;
          if (accept) begin
            state <= ST_RUN;
            step  <= '0;
            set_q <= rate_sel;
          end
        end
        ST_RUN: begin
          pv_q <= 1'b1;
          if (last_step) begin
            pair_q <= (SMP_W+1)'(near_smp);
            ctr_q  <= near_smp;
            state  <= ST_DRAIN;
          end else begin
            pair_q <= (SMP_W+1)'(near_smp) + (SMP_W+1)'(far_smp);
          end
          step <= step + 1'b1;
        end
        ST_DRAIN: begin
          pv_q  <= 1'b0;
          state <= ST_FINISH;
        end
        ST_FINISH: begin
          pend_lp <= {lp_smp, 16'h0000};
          pend_hp <= hp_diff <<< 15;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lp_word   <= '0;
      hp_word   <= '0;
    end else begin
      out_valid <= accept;
      if (mute) begin
        lp_word <= '0;
        hp_word <= '0;
      end else if (accept) begin
        lp_word <= pend_lp;
        hp_word <= pend_hp;
      end
    end
  end

  AST_LP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    lp_word[15:0] == 16'h0000); // R5
  AST_HP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[14:0] == 15'h0000); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !mute) |=> ($stable(lp_word) && $stable(hp_word))); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R7
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> (lp_word == 32'h0 && hp_word == 32'h0)); // R8
  AST_SET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(set_q)); // R3

endmodule

// File: tb/xover_crossover_test.sv
module xover_crossover_test;

  localparam int TAPS = 9;
  localparam int CS   = 12;
  localparam int IW   = 24;
  localparam int C    = (TAPS - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [IW-1:0] in_word = '0;
  logic          rate_sel = 1'b0;
  logic          link_ok = 1'b1;
  logic          rate_fast = 1'b0;
  logic          out_valid;
  logic [31:0]   lp_word;
  logic [31:0]   hp_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint hist [TAPS];
  logic [31:0] exp_lp = '0;
  logic [31:0] exp_hp = '0;

  always #5 clk = ~clk;

  xover_crossover #(.TAPS(TAPS), .COEF_SHIFT(CS), .IN_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .rate_sel(rate_sel), .link_ok(link_ok), .rate_fast(rate_fast),
    .out_valid(out_valid), .lp_word(lp_word), .hp_word(hp_word)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint coef_of(input int k, input bit s);
    longint one, den;
    int m;
    one = longint'(1) << CS;
    m = (k <= C) ? k : TAPS - 1 - k;
    if (!s) begin
      den = longint'(C + 1) * longint'(C + 1);
      return longint'(m + 1) * ((one + den - 1) / den);
    end
    return (one + TAPS - 1) / TAPS;
  endfunction

  // R2 R3 R4 R5 model of one sample's outputs
  task automatic model_push(input logic [IW-1:0] w, input bit s);
    longint sum, lp, hp;
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(w[IW-1 -: 16]));
    sum = 0;
    for (int k = 0; k < TAPS; k++) sum += coef_of(k, s) * hist[k];
    lp = sum >>> CS;
    if (lp > 32767) lp = 32767;
    if (lp < -32768) lp = -32768;
    hp = hist[C] - lp;
    exp_lp = 32'(lp) << 16;
    exp_hp = 32'(hp) << 15;
  endtask

  task automatic send(input logic [IW-1:0] w, input bit s, input bit ok, input bit fast);
    bit muted;
    while (!in_ready) @(negedge clk);
    in_word = w; rate_sel = s; link_ok = ok; rate_fast = fast; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    muted = !ok || fast;
    check("R6", "out_valid on accept", 32'(out_valid), 32'd1);
    check(muted ? "R8" : "R2", "lp_word", lp_word, muted ? 32'h0 : exp_lp);
    check(muted ? "R8" : "R4", "hp_word", hp_word, muted ? 32'h0 : exp_hp);
    model_push(w, s);
    @(negedge clk);
    check("R6", "out_valid single", 32'(out_valid), 32'd0);
    check("R7", "in_ready busy", 32'(in_ready), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int busy;
    logic [31:0] hold_lp, hold_hp;
    void'($urandom(32'd4711));
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", "in_ready", 32'(in_ready), 32'd1);
    check("R9", "out_valid", 32'(out_valid), 32'd0);
    check("R9", "lp_word", lp_word, 32'h0);
    check("R9", "hp_word", hp_word, 32'h0);

    // R3 impulse through the tapered set, R1 low bits discarded
    send({16'h4000, 8'hff}, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < TAPS + 1; i++) send({16'h0000, 8'(i * 37)}, 1'b0, 1'b1, 1'b0);

    // R7 busy length: count cycles until ready returns
    send({16'h1000, 8'h00}, 1'b1, 1'b1, 1'b0);
    busy = 1;
    while (!in_ready) begin busy++; @(negedge clk); end
    check("R7", "busy cycles", 32'(busy), 32'(C + 3));

    // R2 saturation at both full scales and both sets
    for (int i = 0; i < TAPS + 1; i++) send({16'h7fff, 8'h00}, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < TAPS + 1; i++) send({16'h8000, 8'h00}, 1'b1, 1'b1, 1'b0);

    // R4 high band beyond 16 bits: full positive around a negative centre
    for (int i = 0; i < TAPS; i++) send((i == C) ? {16'h8000, 8'h00} : {16'h7fff, 8'h00}, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < TAPS; i++) send((i == C) ? {16'h8002, 8'h00} : {16'h0001, 8'h00}, 1'b0, 1'b1, 1'b0);
    send(24'h0, 1'b0, 1'b1, 1'b0);

    // R7 strobe while busy is ignored
    send({16'h2222, 8'h00}, 1'b0, 1'b1, 1'b0);
    hold_lp = lp_word; hold_hp = hp_word;
    check("R7", "ready low before stray strobe", 32'(in_ready), 32'd0);
    in_word = {16'h5a5a, 8'h00}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7", "lp held after stray", lp_word, hold_lp);
    check("R7", "hp held after stray", hp_word, hold_hp);
    check("R7", "no strobe after stray", 32'(out_valid), 32'd0);
    for (int i = 0; i < TAPS; i++) send({16'h0100, 8'h00}, 1'b0, 1'b1, 1'b0);

    // R8 mute while idle
    while (!in_ready) @(negedge clk);
    link_ok = 1'b0;
    @(negedge clk);
    check("R8", "lp muted idle", lp_word, 32'h0);
    check("R8", "hp muted idle", hp_word, 32'h0);
    link_ok = 1'b1; rate_fast = 1'b1;
    @(negedge clk);
    check("R8", "hp muted fast", hp_word, 32'h0);
    rate_fast = 1'b0;

    // random mix of samples, rates and mute
    for (int n = 0; n < 300; n++) begin
      logic [IW-1:0] w;
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)      w = {16'h7fff, 8'($urandom)};
      else if (r == 1) w = {16'h8000, 8'($urandom)};
      else             w = IW'($urandom);
      send(w, 1'($urandom), ($urandom_range(0, 9) != 0), ($urandom_range(0, 14) == 0));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 6)) @(negedge clk);
    end
    send(24'h0, 1'b0, 1'b1, 1'b0);
    finish_run();
  end

endmodule